// File: doc/BRIEF.md
# Keyed Write Guard for Flash Area Select

This block protects one critical control register, the flash area-select register, from stray software writes. Software first writes a fixed 32-bit key to a key location. That opens a short window of clock cycles, and during the window exactly one write to the guarded register takes effect. A write to the guarded register at any other time is dropped, and a sticky error flag records it.

Each implemented bit of the guarded register places one flash area in write mode (1) or read mode (0). The most significant implemented bit belongs to the data flash area. The register value drives the block's outputs directly. The bus is a plain register interface: address, write enable, write data and combinational read data.

Top module: `keyed_sel_guard`

## Requirements
- R1: After a synchronous active-low reset, `area_sel` is 0 (every area in read mode), the error flag is 0 and the window is closed.
- R2: A write of exactly 0xA74A9D23 to offset 0x0 (key) arms the window. Status bit 1 then reads 1.
- R3: A write to offset 0x1 (select) is accepted when it lands on any of the 16 clock edges that follow the key write edge. A write on the 17th edge or later is rejected.
- R4: A key write with any other value closes the window at once, even if it was armed.
- R5: An accepted select write closes the window, so a further select write is rejected until a new key is written.
- R6: A rejected select write leaves `area_sel` unchanged and sets status bit 0 (error). The error flag stays set until reset.
- R7: Select bit i puts area i in write mode (1) or read mode (0), and `area_sel` mirrors the register. The top implemented bit (NUM_AREAS-1) is the data flash area, also driven on `data_area_wr`.
- R8: The select register reads back its implemented bits at offset 0x1 with every reserved bit 0, whatever was written. The key location reads 0.
- R9: A correct key written while the window is armed restarts the full 16-edge window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | ADDR_W (4) | Register offset: 0x0 key, 0x1 select, 0x2 status |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Combinational read data for `addr` |
| area_sel | output | NUM_AREAS (5) | Per-area write-mode selects |
| data_area_wr | output | 1 | Write-mode select of the data flash area |

## Verification
A window counter that is off by one shows up as a select write on the 16th or 17th edge after the key landing on the wrong side. It appears in `area_sel` one edge later, and the error bit and status bit 1 show it too. A key compare that ignores some bit shows up as a near-miss key that still lets the next write through. A window that does not close after use shows up as a second write that changes `area_sel` without setting the error bit. A window that does not close after a bad key is seen at the next select write.

// File: rtl/keyed_sel_guard_pkg.sv
// Package: shared offsets, status bit positions and the key event type
// for the keyed select-register guard.
package keyed_sel_guard_pkg;

    // Register offsets on the bus
    localparam int OFS_KEY  = 0;
    localparam int OFS_SEL  = 1;
    localparam int OFS_STAT = 2;

    // Status register bit positions
    localparam int STAT_ERR_BIT   = 0;
    localparam int STAT_ARMED_BIT = 1;

    // Outcome of a bus cycle at the key offset
    typedef enum logic [1:0] {
        KEY_NONE     = 2'd0,
        KEY_MATCH    = 2'd1,
        KEY_MISMATCH = 2'd2
    } key_evt_e;

endpackage

// File: rtl/kg_bus_decode.sv
// Module: kg_bus_decode
// Decodes one bus cycle into a key event and a select-write strobe.
// Assumes: one access per cycle and wr_en qualifies both addr and wdata.
module kg_bus_decode
    import keyed_sel_guard_pkg::*;
#(
    parameter int          ADDR_W   = 4,
    parameter int          DATA_W   = 32,
    parameter logic [31:0] KEY_CODE = 32'hA74A9D23
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output key_evt_e          key_evt,
    output logic              sel_wr
);

    localparam logic [ADDR_W-1:0] A_KEY = ADDR_W'(OFS_KEY);
    localparam logic [ADDR_W-1:0] A_SEL = ADDR_W'(OFS_SEL);
    localparam logic [DATA_W-1:0] KEY_W = DATA_W'(KEY_CODE);

    logic key_hit;

    // Classify a write at the key offset by its data value
    always_comb begin
        key_hit = wr_en && (addr == A_KEY);
        if (!key_hit)
            key_evt = KEY_NONE;
        else if (wdata == KEY_W)
            key_evt = KEY_MATCH;
        else
            key_evt = KEY_MISMATCH;
    end

    // Strobe for a write aimed at the guarded register
    always_comb begin
        sel_wr = wr_en && (addr == A_SEL);
    end

endmodule

// File: rtl/kg_window.sv
// Module: kg_window
// Down-counter that holds the unlock window open for WINDOW edges after a
// correct key. It reloads on a correct key and clears on a bad key or when
// the window is used.
// Assumes: key_evt and consume never both act in one cycle (one access per cycle).
module kg_window
    import keyed_sel_guard_pkg::*;
#(
    parameter int WINDOW = 16,
    localparam int CNT_W = $clog2(WINDOW + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  key_evt_e         key_evt,
    input  logic             consume,
    output logic [CNT_W-1:0] cnt,
    output logic             armed
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WINDOW);

    // Window counter: load, clear or count down
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (key_evt == KEY_MATCH)
            cnt <= CNT_FULL;
        else if (key_evt == KEY_MISMATCH)
            cnt <= '0;
        else if (consume)
            cnt <= '0;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    // Window is open while any count remains
    always_comb begin
        armed = (cnt != '0);
    end

endmodule

// File: rtl/kg_sel_reg.sv
// Module: kg_sel_reg
// The guarded area-select register and its sticky error flag. A write
// updates the register only while armed. Otherwise it sets the error flag.
// Assumes: sel_wr is a single-cycle strobe from the decoder.
module kg_sel_reg #(
    parameter int NUM_AREAS = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel_wr,
    input  logic                 armed,
    input  logic [NUM_AREAS-1:0] wbits,
    output logic [NUM_AREAS-1:0] sel,
    output logic                 err,
    output logic                 accept
);

    logic reject;

    // Qualify the write against the window state
    always_comb begin
        accept = sel_wr && armed;
        reject = sel_wr && !armed;
    end

    // One flop per area select, written only on an accepted write
    for (genvar i = 0; i < NUM_AREAS; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)
                sel[i] <= 1'b0;
            else if (accept)
                sel[i] <= wbits[i];
        end
    end

    // Sticky flag for writes outside the window
    always_ff @(posedge clk) begin
        if (!rst_n)
            err <= 1'b0;
        else if (reject)
            err <= 1'b1;
    end

endmodule

// File: rtl/keyed_sel_guard.sv
// Module: keyed_sel_guard (top)
// Guards the flash area-select register behind a 32-bit key write and a
// short window, and provides readback of select bits and status.
// Assumes: synchronous active-low reset and at most one bus access per cycle.
module keyed_sel_guard
    import keyed_sel_guard_pkg::*;
#(
    parameter int          ADDR_W    = 4,
    parameter int          DATA_W    = 32,
    parameter int          NUM_AREAS = 5,
    parameter int          WINDOW    = 16,
    parameter logic [31:0] KEY_CODE  = 32'hA74A9D23
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    output logic [NUM_AREAS-1:0] area_sel,
    output logic                 data_area_wr
);

    localparam int CNT_W = $clog2(WINDOW + 1);
    localparam int DATA_AREA = NUM_AREAS - 1;
    localparam logic [ADDR_W-1:0] A_SEL  = ADDR_W'(OFS_SEL);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

    key_evt_e         key_evt;
    logic             sel_wr;
    logic [CNT_W-1:0] win_cnt;
    logic             armed;
    logic             accept;
    logic             err_flag;
    logic [NUM_AREAS-1:0] sel_q;

    kg_bus_decode #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .KEY_CODE (KEY_CODE)
    ) u_decode (
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .key_evt (key_evt),
        .sel_wr  (sel_wr)
    );

    kg_window #(
        .WINDOW (WINDOW)
    ) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .key_evt (key_evt),
        .consume (accept),
        .cnt     (win_cnt),
        .armed   (armed)
    );

    kg_sel_reg #(
        .NUM_AREAS (NUM_AREAS)
    ) u_sel (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_wr (sel_wr),
        .armed  (armed),
        .wbits  (wdata[NUM_AREAS-1:0]),
        .sel    (sel_q),
        .err    (err_flag),
        .accept (accept)
    );

    // Drive the area outputs from the guarded register
    always_comb begin
        area_sel     = sel_q;
        data_area_wr = sel_q[DATA_AREA];
    end

    // Read mux: unimplemented and reserved bits read as zero
    always_comb begin
        rdata = '0;
        if (addr == A_SEL)
            rdata[NUM_AREAS-1:0] = sel_q;
        else if (addr == A_STAT) begin
            rdata[STAT_ERR_BIT]   = err_flag;
            rdata[STAT_ARMED_BIT] = armed;
        end
    end

endmodule

// File: rtl/keyed_sel_guard_chk.sv
// Module: keyed_sel_guard_chk
// Property checker bound to keyed_sel_guard. It watches the bus, the
// outputs and the window counter.
module keyed_sel_guard_chk
    import keyed_sel_guard_pkg::*;
#(
    parameter int          ADDR_W    = 4,
    parameter int          DATA_W    = 32,
    parameter int          NUM_AREAS = 5,
    parameter int          WINDOW    = 16,
    parameter logic [31:0] KEY_CODE  = 32'hA74A9D23,
    localparam int         CNT_W     = $clog2(WINDOW + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic [ADDR_W-1:0]    addr,
    input logic [DATA_W-1:0]    wdata,
    input logic [DATA_W-1:0]    rdata,
    input logic [NUM_AREAS-1:0] area_sel,
    input logic [CNT_W-1:0]     win_cnt,
    input logic                 err_flag
);

    localparam logic [ADDR_W-1:0] A_KEY = ADDR_W'(OFS_KEY);
    localparam logic [ADDR_W-1:0] A_SEL = ADDR_W'(OFS_SEL);
    localparam logic [DATA_W-1:0] KEY_W = DATA_W'(KEY_CODE);

    logic key_ok, key_bad, sel_in, sel_out;
    assign key_ok  = wr_en && addr == A_KEY && wdata == KEY_W;
    assign key_bad = wr_en && addr == A_KEY && wdata != KEY_W;
    assign sel_in  = wr_en && addr == A_SEL && win_cnt != '0;
    assign sel_out = wr_en && addr == A_SEL && win_cnt == '0;

    AST_KEY_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        key_ok |=> win_cnt == CNT_W'(WINDOW)); // R2
    AST_BAD_KEY_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        key_bad |=> win_cnt == '0); // R4
    AST_WIN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        win_cnt <= CNT_W'(WINDOW)); // R3
    AST_ACCEPT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        sel_in |=> area_sel == $past(wdata[NUM_AREAS-1:0])); // R3
    AST_SINGLE_USE: assert property (@(posedge clk) disable iff (!rst_n)
        sel_in |=> win_cnt == '0); // R5
    AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        sel_out |=> $stable(area_sel) && err_flag); // R6
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag); // R6
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        addr == A_SEL |-> rdata[DATA_W-1:NUM_AREAS] == '0); // R8

endmodule

bind keyed_sel_guard keyed_sel_guard_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .NUM_AREAS (NUM_AREAS),
    .WINDOW    (WINDOW),
    .KEY_CODE  (KEY_CODE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .area_sel (area_sel),
    .win_cnt  (win_cnt),
    .err_flag (err_flag)
);

// File: tb/test_keyed_sel_guard.sv
// Bench for keyed_sel_guard: sweeps the write delay after the key, flips
// each key bit, and exercises re-arming and single use.
module test_keyed_sel_guard;

    localparam int CLK_PERIOD = 10;
    localparam int NA = 5;
    localparam int WIN = 16;
    localparam logic [31:0] KEY = 32'hA74A9D23;
    localparam logic [3:0] A_KEY = 4'h0, A_SEL = 4'h1, A_STAT = 4'h2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [3:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [NA-1:0] area_sel;
    logic data_area_wr;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [NA-1:0] exp_sel;
    logic exp_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    keyed_sel_guard i_keyed_sel_guard (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .area_sel(area_sel),
        .data_area_wr(data_area_wr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge
    task automatic do_reset();
        rst_n = 1'b0; wr_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        exp_sel = '0; exp_err = 1'b0;
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Compare outputs and readback with the bench model
    task automatic check_state(input string req);
        logic [31:0] r;
        check({req, " area_sel"}, 32'(area_sel), 32'(exp_sel));
        check({req, " R7 data_area_wr"}, 32'(data_area_wr), 32'(exp_sel[NA-1]));
        bus_rd(A_SEL, r);
        check({req, " R8 readback"}, r, 32'(exp_sel));
        bus_rd(A_STAT, r);
        check({req, " R6 err"}, 32'(r[0]), 32'(exp_err));
    endtask

    initial begin
        logic [31:0] r;
        logic [31:0] pat;
        @(negedge clk);
        do_reset();
        // R1: reset state
        check_state("R1");
        bus_rd(A_STAT, r);
        check("R1 window closed", 32'(r[1]), 32'd0);
        bus_rd(A_KEY, r);
        check("R8 key reads zero", r, 32'd0);

        // R3/R7/R8: sweep write delay 1..20 edges after the key
        for (int d = 1; d <= 20; d++) begin
            do_reset();
            bus_wr(A_KEY, KEY);
            bus_rd(A_STAT, r);
            check("R2 armed after key", 32'(r[1]), 32'd1);
            idle(d - 1);
            bus_rd(A_STAT, r);
            check("R3 armed before write", 32'(r[1]), 32'(d <= WIN));
            pat = 32'hFFFF_FFE0 | 32'((d * 11 + 3) % 32);
            bus_wr(A_SEL, pat);
            if (d <= WIN) exp_sel = pat[NA-1:0];
            else exp_err = 1'b1;
            check_state("R3");
            // R5: second write without a new key is rejected
            bus_wr(A_SEL, ~pat);
            exp_err = 1'b1;
            check_state("R5");
        end

        // R4: every single-bit-flipped key closes an armed window
        for (int b = 0; b < 32; b++) begin
            do_reset();
            bus_wr(A_KEY, KEY);
            bus_wr(A_KEY, KEY ^ (32'd1 << b));
            bus_rd(A_STAT, r);
            check("R4 bad key closes", 32'(r[1]), 32'd0);
            bus_wr(A_SEL, 32'h1F);
            exp_err = 1'b1;
            check_state("R4");
        end

        // R9: a second correct key restarts the window
        do_reset();
        bus_wr(A_KEY, KEY);
        idle(10);
        bus_wr(A_KEY, KEY);
        idle(15);
        bus_wr(A_SEL, 32'h15);
        exp_sel = 5'h15;
        check_state("R9");

        // R6: error stays set across a later accepted write
        bus_wr(A_SEL, 32'h0A);
        exp_err = 1'b1;
        bus_wr(A_KEY, KEY);
        bus_wr(A_SEL, 32'h0A);
        exp_sel = 5'h0A;
        check_state("R6 sticky");

        // R1: reset clears select and error
        do_reset();
        check_state("R1 after use");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule